// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the status word of a small processor core. Six condition flags record properties of the most recent add or subtract: carry or borrow, low-byte parity, nibble carry, zero, sign and signed overflow. Three control flags (trap, interrupt enable and string direction) steer the rest of the core. The condition flags are derived from the two operands, the ALU result and two mode inputs. One mode input selects subtraction. The other selects a 16-bit or 8-bit operation.

A per-group update mask chooses which condition flags a given ALU operation may change. This lets logical operations leave carry and overflow untouched. Interrupt enable and direction each have dedicated set and clear commands. When an interrupt is taken, the trap and interrupt-enable flags are cleared. A full-word load serves both a stack pop and an interrupt return, which restores the saved flags. This load is the only way to write the trap flag. The whole word is always visible on one output, in the form a stack push would store it.

Top module: `status_flag_reg`

## Requirements
- R1: After an active-low reset every flag is 0, and the status word reads 16'hF02A.
- R2: Bits 1, 3, 5 and 12 to 15 always read as 1, whatever value is loaded. Only bits 0, 2, 4, 6, 7, 8, 9, 10 and 11 hold state.
- R3: Carry (bit 0) is set on a carry out of the operation's top bit for addition (opSub=0), or a borrow into it for subtraction (opSub=1). The top bit is bit 15 when opWide=1 and bit 7 when opWide=0.
- R4: Parity (bit 2) is set when bits 7:0 of the result hold an even number of ones. This applies in both widths.
- R5: Auxiliary carry (bit 4) is set on a carry out of bit 3 for addition, or a borrow from bit 4 into bit 3 for subtraction.
- R6: Zero (bit 6) is set when the result is zero over the operation width, and sign (bit 7) copies the result's top bit. In byte mode, bits 15:8 of the operands and the result have no effect on any flag.
- R7: Overflow (bit 11) is set when the signed two's-complement result does not fit the operation width.
- R8: Condition flags change only when aluValid=1. updMask[0] enables carry, updMask[1] overflow, updMask[2] zero, sign and parity together, and updMask[3] auxiliary carry. A flag whose mask bit is 0 keeps its value.
- R9: The ctrlCmd codes act on the next edge: 1 sets interrupt enable (bit 9), 2 clears it, 3 sets direction (bit 10), 4 clears it. Codes 0, 5, 6 and 7 do nothing.
- R10: intAck=1 clears trap (bit 8) and interrupt enable (bit 9) on the next edge. The ctrlCmd value in that cycle is ignored, while an ALU update in the same cycle still applies.
- R11: loadEn=1 writes the implemented bits of loadWord into the register on the next edge and overrides every other input in that cycle. The trap flag changes only through this load or through intAck.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| aluValid | input | 1 | Condition flags may update this cycle |
| opSub | input | 1 | 1 = subtraction, 0 = addition |
| opWide | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand (subtrahend when opSub=1) |
| aluRes | input | 16 | ALU result belonging to the operands |
| updMask | input | 4 | Per-group condition flag update enables |
| ctrlCmd | input | 3 | Control flag command code |
| intAck | input | 1 | Interrupt recognised this cycle |
| loadEn | input | 1 | Full-word load (pop or interrupt return) |
| loadWord | input | 16 | Word to load |
| statusWord | output | 16 | Current status word |

## Verification
The status word is the register itself with constant ones ORed into the unused positions. Any wrong internal flag therefore appears at statusWord one edge after the input that caused it, and it stays visible until a later update rewrites that flag. A wrong condition flag shows up as soon as an update with that group masked off, or a load, fails to put it right. A dropped or stuck control flag persists across many ALU cycles. A cycle-by-cycle model that compares every field after every edge therefore pins each fault to the first cycle it appears.

// File: rtl/status_pkg.sv
package status_pkg;
  localparam int REG_W    = 16;
  localparam int CF_POS   = 0;
  localparam int PF_POS   = 2;
  localparam int AF_POS   = 4;
  localparam int ZF_POS   = 6;
  localparam int SF_POS   = 7;
  localparam int TF_POS   = 8;
  localparam int IE_POS   = 9;
  localparam int DIR_POS  = 10;
  localparam int OF_POS   = 11;

  // positions that hold state, and the constant pattern of the rest
  localparam logic [REG_W-1:0] IMPL_MASK  = 16'h0FD5;
  localparam logic [REG_W-1:0] FIXED_ONES = 16'hF02A;

  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,
    CMD_SET_IE  = 3'd1,
    CMD_CLR_IE  = 3'd2,
    CMD_SET_DIR = 3'd3,
    CMD_CLR_DIR = 3'd4
  } ctrl_cmd_e;

  typedef struct packed {
    logic loadAll;
    logic updCarry;
    logic updOvf;
    logic updZsp;
    logic updAux;
    logic setIe;
    logic clrIe;
    logic setDir;
    logic clrDir;
    logic clrTrap;
  } flag_strobe_t;
endpackage

// File: rtl/flag_calc.sv
module flag_calc #(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  logic              isSub,
  input  logic              isWide,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] res,
  output logic              cfNext,
  output logic              pfNext,
  output logic              afNext,
  output logic              zfNext,
  output logic              sfNext,
  output logic              ofNext
);
  localparam int NIB_W = LANE_W / 2;

  logic [DATA_W-1:0] opBx;
  logic [DATA_W:0]   chain;

  assign opBx     = opB ^ {DATA_W{isSub}};
  assign chain[0] = isSub;

  // ripple carry chain; subtraction is a + ~b + 1, borrow = ~carry
  for (genvar i = 0; i < DATA_W; i++) begin : g_chain
    assign chain[i+1] = (opA[i] & opBx[i]) | ((opA[i] ^ opBx[i]) & chain[i]);
  end

  logic carryTop, carryIntoTop;

  always_comb begin
    if (isWide) begin
      carryTop     = chain[DATA_W];
      carryIntoTop = chain[DATA_W-1];
      zfNext       = (res == '0);
      sfNext       = res[DATA_W-1];
    end else begin
      carryTop     = chain[LANE_W];
      carryIntoTop = chain[LANE_W-1];
      zfNext       = (res[LANE_W-1:0] == '0);
      sfNext       = res[LANE_W-1];
    end
    cfNext = carryTop ^ isSub;
    ofNext = carryTop ^ carryIntoTop;
    afNext = chain[NIB_W] ^ isSub;
    pfNext = ~^res[7:0];
  end
endmodule

// File: rtl/flag_ctrl.sv
module flag_ctrl
  import status_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         aluValid,
  input  logic [3:0]   updMask,
  input  logic [2:0]   ctrlCmd,
  input  logic         intAck,
  input  logic         loadEn,
  output flag_strobe_t strb
);
  ctrl_cmd_e cmdE;
  assign cmdE = ctrl_cmd_e'(ctrlCmd);

  always_comb begin
    strb = '0;
    if (loadEn) begin
      strb.loadAll = 1'b1;
    end else begin
      strb.updCarry = aluValid & updMask[0];
      strb.updOvf   = aluValid & updMask[1];
      strb.updZsp   = aluValid & updMask[2];
      strb.updAux   = aluValid & updMask[3];
      if (intAck) begin
        strb.clrTrap = 1'b1;
        strb.clrIe   = 1'b1;
      end else begin
        unique case (cmdE)
          CMD_SET_IE:  strb.setIe  = 1'b1;
          CMD_CLR_IE:  strb.clrIe  = 1'b1;
          CMD_SET_DIR: strb.setDir = 1'b1;
          CMD_CLR_DIR: strb.clrDir = 1'b1;
          default: ;
        endcase
      end
    end
  end

  // R9
  ie_cmd_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.setIe, strb.clrIe}) && $onehot0({strb.setDir, strb.clrDir}));

  // R10
  int_ack_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !loadEn) |-> (strb.clrTrap && strb.clrIe && !strb.setIe && !strb.setDir && !strb.clrDir));

  // R11
  load_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadAll |-> !(strb.updCarry || strb.updOvf || strb.updZsp || strb.updAux || strb.clrTrap
                       || strb.setIe || strb.clrIe || strb.setDir || strb.clrDir));
endmodule

// File: rtl/flag_store.sv
module flag_store
  import status_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  flag_strobe_t     strb,
  input  logic             cfNext,
  input  logic             pfNext,
  input  logic             afNext,
  input  logic             zfNext,
  input  logic             sfNext,
  input  logic             ofNext,
  input  logic [REG_W-1:0] loadWord,
  output logic [REG_W-1:0] statusWord
);
  logic [REG_W-1:0] flagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
    end else if (strb.loadAll) begin
      flagQ <= loadWord & IMPL_MASK;
    end else begin
      if (strb.updCarry) flagQ[CF_POS] <= cfNext;
      if (strb.updOvf)   flagQ[OF_POS] <= ofNext;
      if (strb.updAux)   flagQ[AF_POS] <= afNext;
      if (strb.updZsp) begin
        flagQ[ZF_POS] <= zfNext;
        flagQ[SF_POS] <= sfNext;
        flagQ[PF_POS] <= pfNext;
      end
      if (strb.clrTrap)     flagQ[TF_POS]  <= 1'b0;
      if (strb.clrIe)       flagQ[IE_POS]  <= 1'b0;
      else if (strb.setIe)  flagQ[IE_POS]  <= 1'b1;
      if (strb.clrDir)      flagQ[DIR_POS] <= 1'b0;
      else if (strb.setDir) flagQ[DIR_POS] <= 1'b1;
    end
  end

  assign statusWord = flagQ | FIXED_ONES;

  // R10
  int_entry_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrTrap && !strb.loadAll) |=> (!flagQ[TF_POS] && !flagQ[IE_POS]));

  // R11
  trap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadAll && !strb.clrTrap) |=> $stable(flagQ[TF_POS]));

  // R11
  load_apply_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadAll |=> (statusWord == (($past(loadWord) & IMPL_MASK) | FIXED_ONES)));

  // R9
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadAll && !strb.setDir && !strb.clrDir) |=> $stable(flagQ[DIR_POS]));

  // R8
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadAll && !strb.updCarry) |=> $stable(flagQ[CF_POS]));

  // R8
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadAll && !strb.updOvf) |=> $stable(flagQ[OF_POS]));
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import status_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aluValid,
  input  logic              opSub,
  input  logic              opWide,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] aluRes,
  input  logic [3:0]        updMask,
  input  logic [2:0]        ctrlCmd,
  input  logic              intAck,
  input  logic              loadEn,
  input  logic [REG_W-1:0]  loadWord,
  output logic [REG_W-1:0]  statusWord
);
  flag_strobe_t strb;
  logic cfNext, pfNext, afNext, zfNext, sfNext, ofNext;

  flag_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .aluValid(aluValid), .updMask(updMask),
    .ctrlCmd(ctrlCmd), .intAck(intAck), .loadEn(loadEn), .strb(strb)
  );

  flag_calc #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_calc (
    .isSub(opSub), .isWide(opWide), .opA(opA), .opB(opB), .res(aluRes),
    .cfNext(cfNext), .pfNext(pfNext), .afNext(afNext),
    .zfNext(zfNext), .sfNext(sfNext), .ofNext(ofNext)
  );

  flag_store u_store (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfNext(cfNext), .pfNext(pfNext), .afNext(afNext),
    .zfNext(zfNext), .sfNext(sfNext), .ofNext(ofNext),
    .loadWord(loadWord), .statusWord(statusWord)
  );
endmodule

// File: tb/sim_status_flag_reg.sv
`timescale 1ns/1ps
module sim_status_flag_reg;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN = 1'b0;
  logic        aluValid = 0, opSub = 0, opWide = 1;
  logic [15:0] opA = 0, opB = 0, aluRes = 0;
  logic [3:0]  updMask = 0;
  logic [2:0]  ctrlCmd = 0;
  logic        intAck = 0, loadEn = 0;
  logic [15:0] loadWord = 0;
  logic [15:0] statusWord;

  int vectors = 0;
  int miscompares = 0;
  logic [15:0] expWord = 16'hF02A;

  status_flag_reg u0 (
    .clk(clk), .rstN(rstN), .aluValid(aluValid), .opSub(opSub), .opWide(opWide),
    .opA(opA), .opB(opB), .aluRes(aluRes), .updMask(updMask), .ctrlCmd(ctrlCmd),
    .intAck(intAck), .loadEn(loadEn), .loadWord(loadWord), .statusWord(statusWord)
  );

  task automatic fieldCheck(string req, string what, logic [15:0] msk);
    if ((statusWord & msk) !== (expWord & msk)) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, statusWord & msk, expWord & msk);
    end
  endtask

  task automatic compareAll();
    vectors++;
    fieldCheck("R2",  "fixed bits",  16'hF02A);
    fieldCheck("R3",  "carry",       16'h0001);
    fieldCheck("R4",  "parity",      16'h0004);
    fieldCheck("R5",  "aux carry",   16'h0010);
    fieldCheck("R6",  "zero/sign",   16'h00C0);
    fieldCheck("R7",  "overflow",    16'h0800);
    fieldCheck("R9",  "direction",   16'h0400);
    fieldCheck("R10", "int enable",  16'h0200);
    fieldCheck("R11", "trap",        16'h0100);
  endtask

  // behavioural reference, evaluated with the inputs present at the edge
  task automatic modelEdge();
    int full, half, ua, ub, raw, r, la, lb, sa, sb, sr;
    logic cf, pf, af, zf, sf, ovf;
    logic [7:0] lowB;
    if (loadEn) begin
      expWord = (loadWord & 16'h0FD5) | 16'hF02A;
      return;
    end
    if (aluValid) begin
      full = opWide ? 65536 : 256;
      half = full / 2;
      ua = int'(opA) % full;
      ub = int'(opB) % full;
      raw = opSub ? ua - ub : ua + ub;
      r = (raw + full) % full;
      cf = opSub ? (ua < ub) : (raw >= full);
      la = ua % 16; lb = ub % 16;
      af = opSub ? (la < lb) : (la + lb > 15);
      sa = (ua >= half) ? ua - full : ua;
      sb = (ub >= half) ? ub - full : ub;
      sr = opSub ? sa - sb : sa + sb;
      ovf = (sr < -half) || (sr >= half);
      zf = (r == 0);
      sf = (r >= half);
      lowB = 8'(r % 256);
      pf = ($countones(lowB) % 2) == 0;
      if (updMask[0]) expWord[0] = cf;
      if (updMask[1]) expWord[11] = ovf;
      if (updMask[2]) begin expWord[6] = zf; expWord[7] = sf; expWord[2] = pf; end
      if (updMask[3]) expWord[4] = af;
    end
    if (intAck) begin
      expWord[8] = 1'b0;
      expWord[9] = 1'b0;
    end else begin
      case (ctrlCmd)
        3'd1: expWord[9] = 1'b1;
        3'd2: expWord[9] = 1'b0;
        3'd3: expWord[10] = 1'b1;
        3'd4: expWord[10] = 1'b0;
        default: ;
      endcase
    end
  endtask

  task automatic cycle(input logic v, input logic s, input logic w,
                       input logic [15:0] a, input logic [15:0] b, input logic [3:0] m,
                       input logic [2:0] c, input logic ack, input logic ld, input logic [15:0] lw);
    @(negedge clk);
    aluValid = v; opSub = s; opWide = w; opA = a; opB = b;
    aluRes = s ? a - b : a + b;
    updMask = m; ctrlCmd = c; intAck = ack; loadEn = ld; loadWord = lw;
    @(posedge clk);
    #1;
    modelEdge();
    compareAll();
  endtask

  task automatic idle();
    cycle(0, 0, 1, 16'h0, 16'h0, 4'h0, 3'd0, 0, 0, 16'h0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    vectors++;
    if (statusWord !== 16'hF02A) begin
      miscompares++;
      $display("FAIL R1 reset word: actual %h expected %h", statusWord, 16'hF02A);
    end
    @(negedge clk);
    rstN = 1'b1;
    idle();
    // R3 R5 R6: word wrap to zero with carry and nibble carry
    cycle(1, 0, 1, 16'hFFFF, 16'h0001, 4'hF, 3'd0, 0, 0, 16'h0);
    // R7: signed overflow into negative
    cycle(1, 0, 1, 16'h7FFF, 16'h0001, 4'hF, 3'd0, 0, 0, 16'h0);
    // R6: byte mode ignores high bytes, low byte is zero
    cycle(1, 0, 0, 16'h12FF, 16'h3401, 4'hF, 3'd0, 0, 0, 16'h0);
    // R7: byte overflow 0x7F + 1
    cycle(1, 0, 0, 16'hAA7F, 16'h0001, 4'hF, 3'd0, 0, 0, 16'h0);
    // R3 R5: borrow on 0 - 1
    cycle(1, 1, 1, 16'h0000, 16'h0001, 4'hF, 3'd0, 0, 0, 16'h0);
    // R7: 0x8000 - 1 overflows
    cycle(1, 1, 1, 16'h8000, 16'h0001, 4'hF, 3'd0, 0, 0, 16'h0);
    // R4: odd and even low-byte parity with high byte set
    cycle(1, 0, 1, 16'hFF01, 16'h0000, 4'hF, 3'd0, 0, 0, 16'h0);
    cycle(1, 0, 1, 16'hFE03, 16'h0000, 4'hF, 3'd0, 0, 0, 16'h0);
    // R8: mask off everything, then only carry
    cycle(1, 0, 1, 16'hFFFF, 16'h0001, 4'h0, 3'd0, 0, 0, 16'h0);
    cycle(1, 0, 1, 16'hFFFF, 16'h0001, 4'h1, 3'd0, 0, 0, 16'h0);
    cycle(1, 1, 1, 16'h0010, 16'h0001, 4'h8, 3'd0, 0, 0, 16'h0);
    // R9: commands, including unused codes
    cycle(0, 0, 1, 16'h0, 16'h0, 4'h0, 3'd1, 0, 0, 16'h0);
    cycle(0, 0, 1, 16'h0, 16'h0, 4'h0, 3'd3, 0, 0, 16'h0);
    cycle(0, 0, 1, 16'h0, 16'h0, 4'h0, 3'd7, 0, 0, 16'h0);
    cycle(0, 0, 1, 16'h0, 16'h0, 4'h0, 3'd2, 0, 0, 16'h0);
    cycle(0, 0, 1, 16'h0, 16'h0, 4'h0, 3'd4, 0, 0, 16'h0);
    // R11: load all ones sets trap; R2 fixed bits stay 1 after loading zero
    cycle(0, 0, 1, 16'h0, 16'h0, 4'h0, 3'd0, 0, 1, 16'hFFFF);
    // R10: interrupt entry with a set-enable command in the same cycle
    cycle(0, 0, 1, 16'h0, 16'h0, 4'h0, 3'd1, 1, 0, 16'h0);
    // R11: return load restores trap and enable, overriding intAck
    cycle(1, 0, 1, 16'h1234, 16'h4321, 4'hF, 3'd2, 1, 1, 16'h0300);
    cycle(0, 0, 1, 16'h0, 16'h0, 4'h0, 3'd0, 0, 1, 16'h0000);
    // R10: intAck with ALU update still applies condition flags
    cycle(1, 1, 0, 16'h0005, 16'h0005, 4'hF, 3'd3, 1, 0, 16'h0);
    // random traffic, all requirements
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] rnd;
      rnd = $urandom;
      cycle(rnd[0] | rnd[1], rnd[2], rnd[3], 16'($urandom), 16'($urandom),
            rnd[4] ? 4'hF : 4'(rnd[11:8]), 3'(rnd[14:12]),
            (rnd[17:15] == 3'd0), (rnd[20:18] == 3'd0), 16'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule